// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block lets a clocked system use an external asynchronous static RAM of 8192 bytes. On the user side it has a request/ready handshake. A request carries a 13-bit address, a write flag and 8-bit write data. Read data comes back with a one-cycle valid strobe. On the memory side it drives two chip enables of opposite polarity, a write strobe, an output enable, the address bus and a split data bus. The split bus has an outbound value, an inbound value and a driver-enable line for the pad.

Every memory phase is a count of clock cycles. Each count is derived at elaboration from the clock period and the memory's minimum timings, all given in picoseconds.

Writes are framed by the write strobe while the chip is selected and output enable stays high. The controller drives the data bus only after the memory has had time to release it. It holds the data across the edge that ends the write. After a read, at least one dead cycle passes before a write can begin. Between requests the chip is deselected, which puts the memory into standby.

Top module: `sram_ctl`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `ready_o` is 1, `rvalid_o` is 0, `mem_ce_n_o`, `mem_we_n_o` and `mem_oe_n_o` are 1, and `mem_ce_o` and `mem_dq_oe_o` are 0.
- R2: Whenever `ready_o` is 1 the memory is deselected (`mem_ce_n_o` = 1, `mem_ce_o` = 0).
- R3: A read (request with `wr_i` = 0) keeps the chip selected, `mem_oe_n_o` = 0 and `mem_we_n_o` = 1 for RD_CYC = ceil(max(tAA, tACE, tDOE) / Tclk) cycles, which is 3 at the defaults. `ready_o` is low for exactly those cycles.
- R4: A read's `rvalid_o` is high for exactly one cycle, RD_CYC cycles after the accepting edge. `rdata_o` then holds the memory content at the requested address, or the last value written to it. `ready_o` is already 1 in that cycle.
- R5: During a write `mem_oe_n_o` stays 1. `mem_we_n_o` stays 0 for PWE_CYC = max(ceil(tPWE / Tclk), REL_CYC + SD_CYC) cycles, which is 4 at the defaults.
- R6: `mem_dq_oe_o` rises only after `mem_we_n_o` has been 0 for REL_CYC = ceil(tHZWE / Tclk) cycles (2 at the defaults). It is never 1 while `mem_oe_n_o` is 0.
- R7: Write data is driven for PWE_CYC − REL_CYC cycles (2 at the defaults, at least ceil(tSD / Tclk)) before `mem_we_n_o` rises. It stays driven in the cycle after that rise. `mem_addr_o` does not change while the chip is selected.
- R8: In the cycle after `mem_oe_n_o` returns high, `mem_we_n_o` is still 1. A write that follows a read gets one extra deselected cycle before its strobe.
- R9: A request is taken only on an edge where `ready_o` is 1, and `ready_o` is 0 in the next cycle. A write keeps `ready_o` low for PWE_CYC + REC_CYC cycles, which is 5 at the defaults. If the previous accepted request was a read, the write keeps `ready_o` low for one cycle more (6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request valid |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Controller idle, request taken on this edge |
| rvalid_o | output | 1 | Read data valid strobe |
| rdata_o | output | DATA_W | Read data |
| mem_ce_n_o | output | 1 | Active-low chip enable |
| mem_ce_o | output | 1 | Active-high chip enable |
| mem_we_n_o | output | 1 | Active-low write strobe |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Outbound data |
| mem_dq_oe_o | output | 1 | Pad driver enable for outbound data |
| mem_dq_i | input | DATA_W | Inbound data from the memory |

## Verification
The bench drives a memory model that returns valid data only 15 ns after its last control or address change. The model stores a corrupted byte if the write data was not driven at least 8 ns before the strobe rose. This makes a read phase or a data phase that is one cycle short appear as a data miscompare.

Directed patterns cover the following cases, and each one separates a different failure:
- the lowest and highest addresses, which catch address truncation;
- a read of a never-written location;
- a read followed at once by a write, which catches a missing turnaround cycle through the busy count;
- two writes to the same address, which catch write-order errors.

A seeded random mix then varies address locality, operation order and idle gaps. It checks read data, read latency, busy length, strobe width and data-release counts on every operation.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_RD,
    ST_WR_REL,
    ST_WR_DRV,
    ST_WR_END
  } ctl_state_e;

  function automatic int unsigned cdiv(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned RD_LD  = 2,
  parameter int unsigned REL_LD = 1,
  parameter int unsigned DRV_LD = 1,
  parameter int unsigned REC_LD = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             done_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             ce_n_o,
  output logic             ce_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o
);
  ctl_state_e state_q, state_d;
  logic       prev_rd_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        if (!wr_i) begin
          state_d    = ST_RD;
          load_val_o = CNT_W'(RD_LD);
        end else if (prev_rd_q) begin
          state_d    = ST_GAP;           // turnaround after a read
        end else begin
          state_d    = ST_WR_REL;
          load_val_o = CNT_W'(REL_LD);
        end
      end
      ST_GAP: begin
        state_d    = ST_WR_REL;
        load_o     = 1'b1;
        load_val_o = CNT_W'(REL_LD);
      end
      ST_RD: if (done_i) begin
        state_d   = ST_IDLE;
        capture_o = 1'b1;
      end
      ST_WR_REL: if (done_i) begin
        state_d    = ST_WR_DRV;
        load_o     = 1'b1;
        load_val_o = CNT_W'(DRV_LD);
      end
      ST_WR_DRV: if (done_i) begin
        state_d    = ST_WR_END;
        load_o     = 1'b1;
        load_val_o = CNT_W'(REC_LD);
      end
      ST_WR_END: if (done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      prev_rd_q <= 1'b0;
      ready_o   <= 1'b1;
      ce_n_o    <= 1'b1;
      ce_o      <= 1'b0;
      we_n_o    <= 1'b1;
      oe_n_o    <= 1'b1;
      dq_oe_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (capture_o)     prev_rd_q <= 1'b1;
      else if (accept_o) prev_rd_q <= 1'b0;
      // pins registered from next state: glitch-free, aligned with state_q
      ready_o <= (state_d == ST_IDLE);
      ce_n_o  <= !(state_d inside {ST_RD, ST_WR_REL, ST_WR_DRV, ST_WR_END});
      ce_o    <=  (state_d inside {ST_RD, ST_WR_REL, ST_WR_DRV, ST_WR_END});
      we_n_o  <= !(state_d inside {ST_WR_REL, ST_WR_DRV});
      oe_n_o  <= !(state_d == ST_RD);
      dq_oe_o <=  (state_d inside {ST_WR_DRV, ST_WR_END});
    end
  end
endmodule

// File: rtl/sram_ctl_dp.sv
`timescale 1ns/1ps
module sram_ctl_dp #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
    end else begin
      if (accept_i) begin
        mem_addr_o <= addr_i;
        mem_dq_o   <= wdata_i;
      end
      if (capture_i) rdata_o <= mem_dq_i;
      rvalid_o <= capture_i;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_AA_PS   = 15000,
  parameter int unsigned T_ACE_PS  = 15000,
  parameter int unsigned T_DOE_PS  = 8000,
  parameter int unsigned T_PWE_PS  = 12000,
  parameter int unsigned T_SD_PS   = 8000,
  parameter int unsigned T_HZWE_PS = 7000,
  parameter int unsigned T_WC_PS   = 15000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned RD_CYC  = umax(1, cdiv(umax(umax(T_AA_PS, T_ACE_PS), T_DOE_PS), CLK_PS));
  localparam int unsigned REL_CYC = umax(1, cdiv(T_HZWE_PS, CLK_PS));
  localparam int unsigned SD_CYC  = umax(1, cdiv(T_SD_PS, CLK_PS));
  localparam int unsigned PWE_CYC = umax(cdiv(T_PWE_PS, CLK_PS), REL_CYC + SD_CYC);
  localparam int unsigned DRV_CYC = PWE_CYC - REL_CYC;
  localparam int unsigned REC_CYC = (cdiv(T_WC_PS, CLK_PS) > PWE_CYC + 1) ?
                                    cdiv(T_WC_PS, CLK_PS) - PWE_CYC : 1;
  localparam int unsigned MAX_CYC = umax(umax(RD_CYC, REL_CYC), umax(DRV_CYC, REC_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             load, done, accept, capture;
  logic [CNT_W-1:0] load_val;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_ctl_fsm #(
    .CNT_W  (CNT_W),
    .RD_LD  (RD_CYC - 1),
    .REL_LD (REL_CYC - 1),
    .DRV_LD (DRV_CYC - 1),
    .REC_LD (REC_CYC - 1)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .wr_i       (wr_i),
    .done_i     (done),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ready_o    (ready_o),
    .ce_n_o     (mem_ce_n_o),
    .ce_o       (mem_ce_o),
    .we_n_o     (mem_we_n_o),
    .oe_n_o     (mem_oe_n_o),
    .dq_oe_o    (mem_dq_oe_o)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic              mem_ce_n_o,
  input logic              mem_ce_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  always @(posedge clk_i)
    if (!rst_ni)
      assert_reset_idle_R1: assert (ready_o && !rvalid_o && mem_ce_n_o && !mem_ce_o &&
                                    mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o);

  assert_idle_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce_n_o && !mem_ce_o));

  assert_read_ctl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_ce_n_o && mem_ce_o));

  assert_rvalid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_write_oe_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_oe_n_o && !mem_ce_n_o && mem_ce_o));

  assert_no_contention_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  assert_drive_after_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (!mem_we_n_o && $past(!mem_we_n_o)));

  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> mem_dq_oe_o);

  assert_dq_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

  assert_addr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o));

  assert_turnaround_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_n_o) |=> mem_we_n_o);

  assert_accept_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_ce_o    (mem_ce_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;
  localparam int RD_CYC  = 3;   // R3
  localparam int PWE_CYC = 4;   // R5
  localparam int REL_CYC = 2;   // R6
  localparam int DRV_CYC = 2;   // R7
  localparam int WR_BUSY = 5;   // R9

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_i = 1'b0, wr_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o, rvalid_o;
  logic [7:0]  rdata_o;
  logic        mem_ce_n_o, mem_ce_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o;
  logic [12:0] mem_addr_o;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hA5;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit run = 1'b0;
  bit last_rd = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sram_ctl dut_i (.*);

  // ---- memory device model ----
  logic [7:0] dev_mem [int];
  logic [7:0] ref_mem [int];
  time t_chg = 0, t_dq = 0;

  always @(mem_addr_o or mem_oe_n_o or mem_ce_n_o or mem_ce_o or mem_we_n_o) t_chg = $time;
  always @(mem_dq_o or mem_dq_oe_o) t_dq = $time;

  always @(posedge clk_i) begin
    #4;
    if (!mem_ce_n_o && mem_ce_o && !mem_oe_n_o && mem_we_n_o && ($time + 1 - t_chg >= 15))
      mem_dq_i = dev_mem.exists(int'(mem_addr_o)) ? dev_mem[int'(mem_addr_o)] : 8'h00;
    else
      mem_dq_i = 8'hA5;
  end

  always @(posedge mem_we_n_o)
    if (!mem_ce_n_o && mem_ce_o)
      dev_mem[int'(mem_addr_o)] = (mem_dq_oe_o && ($time - t_dq >= 8)) ? mem_dq_o : 8'h3C;

  function automatic logic [7:0] ref_rd(input logic [12:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---- read return queue ----
  logic [7:0] exp_q [$];
  int         acc_q [$];

  // ---- per-cycle monitor ----
  int we_lo = 0, rel_lo = 0, drv_lo = 0, idle_after_rd = 0;
  bit oe_in_wr = 1'b0, prev_we_n = 1'b1, seen_rd = 1'b0;

  always @(negedge clk_i) if (run && rst_ni) begin
    if (ready_o) check(mem_ce_n_o && !mem_ce_o, "R2 deselect when idle", {mem_ce_n_o, mem_ce_o}, 2'b10);
    if (mem_dq_oe_o && !mem_oe_n_o) check(1'b0, "R6 bus contention", 1, 0);
    if (rvalid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected rvalid", 1, 0);
      else begin
        logic [7:0] e;
        int c0;
        e  = exp_q.pop_front();
        c0 = acc_q.pop_front();
        check(rdata_o == e, "R4 read data", rdata_o, e);
        check(cyc - c0 == RD_CYC, "R4 read latency", cyc - c0, RD_CYC);
        check(ready_o, "R4 ready with rvalid", ready_o, 1);
      end
    end
    if (!mem_oe_n_o) begin seen_rd = 1'b1; idle_after_rd = 0; end
    else if (seen_rd && mem_we_n_o) idle_after_rd++;
    if (!mem_we_n_o) begin
      if (prev_we_n && seen_rd) begin
        check(idle_after_rd >= 2, "R8 turnaround cycles", idle_after_rd, 2);
        seen_rd = 1'b0;
      end
      we_lo++;
      if (!mem_dq_oe_o) rel_lo++; else drv_lo++;
      if (!mem_oe_n_o) oe_in_wr = 1'b1;
    end else if (!prev_we_n) begin
      check(we_lo == PWE_CYC, "R5 strobe width", we_lo, PWE_CYC);
      check(!oe_in_wr, "R5 oe high during write", oe_in_wr, 0);
      check(rel_lo == REL_CYC, "R6 release cycles", rel_lo, REL_CYC);
      check(drv_lo == DRV_CYC, "R7 data setup cycles", drv_lo, DRV_CYC);
      check(mem_dq_oe_o, "R7 data hold after strobe", mem_dq_oe_o, 1);
      we_lo = 0; rel_lo = 0; drv_lo = 0; oe_in_wr = 1'b0;
      seen_rd = 1'b0;
    end
    prev_we_n = mem_we_n_o;
  end

  always @(posedge clk_i) cyc++;

  // issue one request, wait for acceptance, then measure busy cycles
  task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
    bit acc;
    int busy, exp_busy;
    req_i = 1'b1; wr_i = wr; addr_i = a; wdata_i = d;
    forever begin
      acc = ready_o;
      @(negedge clk_i);
      if (acc) break;
    end
    req_i = 1'b0;
    if (wr) ref_mem[int'(a)] = d;
    else begin exp_q.push_back(ref_rd(a)); acc_q.push_back(cyc); end
    exp_busy = wr ? (WR_BUSY + (last_rd ? 1 : 0)) : RD_CYC;
    busy = 0;
    while (!ready_o && busy < 50) begin busy++; @(negedge clk_i); end
    check(busy == exp_busy, wr ? "R9 write busy cycles" : "R3 read busy cycles", busy, exp_busy);
    last_rd = !wr;
  endtask

  initial begin : watchdog
    #(5 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(ready_o && !rvalid_o && mem_ce_n_o && !mem_ce_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o,
          "R1 reset state", {ready_o, rvalid_o, mem_ce_n_o, mem_ce_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o},
          7'b1010110);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(ready_o && mem_ce_n_o && !mem_ce_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o,
          "R1 after reset", {ready_o, mem_ce_n_o, mem_ce_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o}, 6'b110110);
    run = 1'b1;

    // directed corners
    issue(1'b1, 13'd0,    8'h11);
    issue(1'b1, 13'h1FFF, 8'hEE);
    issue(1'b0, 13'd0,    8'h00);
    issue(1'b0, 13'h1FFF, 8'h00);
    issue(1'b0, 13'd100,  8'h00);    // never written
    issue(1'b1, 13'd100,  8'h5A);    // write right after read (R8 gap)
    issue(1'b0, 13'd100,  8'h00);
    issue(1'b1, 13'd7,    8'h01);
    issue(1'b1, 13'd7,    8'hFE);    // overwrite
    issue(1'b0, 13'd7,    8'h00);
    repeat (3) @(negedge clk_i);
    issue(1'b1, 13'd8,    8'h77);    // write after idle following read
    issue(1'b0, 13'd8,    8'h00);

    // constrained random
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      bit          w;
      logic [12:0] a;
      w = ($urandom % 2) == 1;
      a = (($urandom % 4) == 0) ? 13'($urandom % 8192) : 13'($urandom % 8);
      issue(w, a, 8'($urandom));
      repeat ($urandom % 3) @(negedge clk_i);
    end

    repeat (10) @(negedge clk_i);
    check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule